// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block holds the collision logic of a two-port shared memory, moved into a single synchronous clock domain. Each port brings an active-low chip enable, a read/write strobe (high reads, low writes) and an address. The block registers a grant when both ports are enabled on the same location. The port that was valid first keeps access. The other port sees an active-low busy flag. Each port also gets a write-allowed qualifier that can feed a memory array directly.

A mode input picks one of two roles. When it is high, the block arbitrates and drives its busy flags. When it is low, the block stops arbitrating and holds its busy outputs high. In that role each port's busy-in pin, supplied by an external arbiter, decides whether that port's writes may pass. Ports that do not collide run fully independently.

Top module: `dp_busy_arb`

## Requirements
- R1: While reset is low at a clock edge, both busy outputs are high after that edge and no grant is held.
- R2: In master mode (`ms_master`=1), when both enables are low and the addresses are equal at a clock edge, exactly one busy output is low after that edge and not before it.
- R3: One edge after the addresses stop matching, both busy outputs are high again.
- R4: One edge after either port raises its chip enable, both busy outputs are high again.
- R5: If the addresses already match when a port lowers its enable, the port that was enabled earlier wins, and the newcomer's busy goes low.
- R6: If both enables are already low when the addresses become equal, the port whose address was unchanged in the previous cycle wins, and the port that changed its address sees busy low.
- R7: If both ports become contending in the same cycle, or neither is newer, the left port wins and `r_busy_n` goes low.
- R8: The two busy outputs are never low at the same time.
- R9: A grant is held for as long as the match persists, including when the winner switches between read and write.
- R10: In slave mode (`ms_master`=0), both busy outputs are high, and a port's write is allowed only while its busy-in input is high.
- R11: A write-allowed output is high only when its port is enabled, is writing (`rw_n`=0), and is not busy.
- R12: With different addresses, both ports write at the same time with no busy raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_master | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from busy-in pins |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left strobe: 1 read, 0 write |
| l_addr | input | ADDR_W | Left address |
| l_busy_in_n | input | 1 | Left external busy in slave mode, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right strobe: 1 read, 0 write |
| r_addr | input | ADDR_W | Right address |
| r_busy_in_n | input | 1 | Right external busy in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_ok | output | 1 | Left write allowed to the array |
| r_wr_ok | output | 1 | Right write allowed to the array |

## Verification
Enable-order and address-order arbitration can both apply in the same cycle. This happens when the two ports reach a matching, enabled state together: one port changes its address while the other lowers its enable, or both change their addresses. The bench creates these cases by changing both ports at the same falling edge. It then expects the left port to win, checking the busy flags and write qualifiers one cycle later. A second collision is the mode switch back to master while a match is already standing. Here neither port is newer, and the bench expects the same left tie-break.

// File: rtl/dpb_pkg.sv
// Shared types for the dual-port busy arbiter.
package dpb_pkg;
    // Which port currently owns a contended location.
    typedef enum logic [1:0] {
        GR_NONE  = 2'd0,
        GR_LEFT  = 2'd1,
        GR_RIGHT = 2'd2
    } grant_e;

    localparam int NPORT = 2;
    localparam int PL = 0;
    localparam int PR = 1;
endpackage

// File: rtl/dpb_port_track.sv
// Per-port arrival tracker.
// Flags a port as "fresh" in a cycle where it is enabled and either was
// disabled last cycle or presents a different address than last cycle.
// Assumes inputs are synchronous to clk.
module dpb_port_track #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              prev_act;
    logic [ADDR_W-1:0] prev_addr;

    // Remember last cycle's enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_act  <= !ce_n;
            prev_addr <= addr;
        end
    end

    // Newly valid this cycle.
    always_comb fresh = !ce_n && (!prev_act || (addr != prev_addr));
endmodule

// File: rtl/dpb_grant_ctl.sv
// Grant register for a contended location.
// Opens a grant when a match appears, picks the earlier port (left on tie),
// holds it while the match persists and clears it one edge after it ends.
// Assumes match is combinational from the current port inputs.
module dpb_grant_ctl
    import dpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ms_master,
    input  logic   match,
    input  logic   l_fresh,
    input  logic   r_fresh,
    output grant_e grant
);
    grant_e grant_nx;

    // Next-grant decision.
    always_comb begin
        if (!ms_master || !match)
            grant_nx = GR_NONE;
        else if (grant != GR_NONE)
            grant_nx = grant;
        else if (l_fresh && !r_fresh)
            grant_nx = GR_RIGHT;
        else
            grant_nx = GR_LEFT;
    end

    // Grant state register.
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= GR_NONE;
        else        grant <= grant_nx;
    end
endmodule

// File: rtl/dpb_wr_gate.sv
// Per-port write qualifier and busy output selection.
// In master mode the internal busy is driven out and gates writes; in slave
// mode the busy output is held high and the busy-in pin gates writes.
module dpb_wr_gate (
    input  logic ms_master,
    input  logic ce_n,
    input  logic rw_n,
    input  logic busy_int_n,
    input  logic busy_in_n,
    output logic busy_out_n,
    output logic wr_ok
);
    logic busy_eff_n;

    // Select the busy source and qualify the write.
    always_comb begin
        busy_eff_n = ms_master ? busy_int_n : busy_in_n;
        busy_out_n = ms_master ? busy_int_n : 1'b1;
        wr_ok      = !ce_n && !rw_n && busy_eff_n;
    end
endmodule

// File: rtl/dp_busy_arb.sv
// Dual-port contention busy arbiter (top).
// Compares the two port addresses, grants the earlier port on a collision,
// flags the loser busy and produces per-port write-allowed qualifiers.
// Assumes all inputs are synchronous to clk; reset is synchronous active low.
module dp_busy_arb
    import dpb_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_master,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_in_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic              ce_n_a   [NPORT];
    logic              rw_n_a   [NPORT];
    logic [ADDR_W-1:0] addr_a   [NPORT];
    logic              bin_a    [NPORT];
    logic              fresh_a  [NPORT];
    logic              bint_a   [NPORT];
    logic              bout_a   [NPORT];
    logic              wrok_a   [NPORT];
    logic              match;
    grant_e            grant;

    // Gather port signals into arrays.
    always_comb begin
        ce_n_a[PL] = l_ce_n;  ce_n_a[PR] = r_ce_n;
        rw_n_a[PL] = l_rw_n;  rw_n_a[PR] = r_rw_n;
        addr_a[PL] = l_addr;  addr_a[PR] = r_addr;
        bin_a[PL]  = l_busy_in_n;
        bin_a[PR]  = r_busy_in_n;
    end

    // Both enabled on one location.
    always_comb match = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    // Internal busy: a port is busy when the other one holds the grant.
    always_comb begin
        bint_a[PL] = (grant != GR_RIGHT);
        bint_a[PR] = (grant != GR_LEFT);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpb_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_n_a[p]),
            .addr  (addr_a[p]),
            .fresh (fresh_a[p])
        );
        dpb_wr_gate u_gate (
            .ms_master  (ms_master),
            .ce_n       (ce_n_a[p]),
            .rw_n       (rw_n_a[p]),
            .busy_int_n (bint_a[p]),
            .busy_in_n  (bin_a[p]),
            .busy_out_n (bout_a[p]),
            .wr_ok      (wrok_a[p])
        );
    end

    dpb_grant_ctl u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_master (ms_master),
        .match     (match),
        .l_fresh   (fresh_a[PL]),
        .r_fresh   (fresh_a[PR]),
        .grant     (grant)
    );

    // Drive ports from the per-port arrays.
    always_comb begin
        l_busy_n = bout_a[PL];
        r_busy_n = bout_a[PR];
        l_wr_ok  = wrok_a[PL];
        r_wr_ok  = wrok_a[PR];
    end
endmodule

// File: rtl/dpb_busy_chk.sv
// Property checker for dp_busy_arb, attached by bind.
// Observes only the top-level ports.
module dpb_busy_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_master,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic same_loc;
    always_comb same_loc = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (l_busy_n && r_busy_n));

    assert_busy_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && same_loc) |=> (!ms_master || !l_busy_n || !r_busy_n));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !same_loc |=> (l_busy_n && r_busy_n));

    assert_one_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    assert_hold_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && same_loc && !r_busy_n) |=> (!ms_master || !same_loc || !r_busy_n));

    assert_slave_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_master |-> (l_busy_n && r_busy_n));

    assert_left_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_ok |-> (!l_ce_n && !l_rw_n));

    assert_right_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr_ok |-> (!r_ce_n && !r_rw_n));

    assert_busy_no_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && !l_busy_n) |-> !l_wr_ok);
endmodule

bind dp_busy_arb dpb_busy_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_master (ms_master),
    .l_ce_n    (l_ce_n),
    .l_rw_n    (l_rw_n),
    .l_addr    (l_addr),
    .r_ce_n    (r_ce_n),
    .r_rw_n    (r_rw_n),
    .r_addr    (r_addr),
    .l_busy_n  (l_busy_n),
    .r_busy_n  (r_busy_n),
    .l_wr_ok   (l_wr_ok),
    .r_wr_ok   (r_wr_ok)
);

// File: tb/dp_busy_arb_test.sv
// Self-checking bench: vector table walk, then directed reset and timing tests.
module dp_busy_arb_test;
    localparam int AW = 17;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_master = 1'b1;
    logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_busy_in_n = 1'b1;
    logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_busy_in_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;
    int            checks = 0;
    int            failures = 0;

    always #4 clk = ~clk;

    dp_busy_arb #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    // Row: ms, lce, lrw, la[8], rce, rrw, ra[8], lbin, rbin,
    //      exp lbusy, exp rbusy, exp lwr, exp rwr, requirement number[5]
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,1'b1,1'b1,8'd0 ,1'b1,1'b1,8'd0 ,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 5'd12}, // R12 idle
        {1'b1,1'b0,1'b0,8'd10,1'b0,1'b0,8'd20,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 5'd12}, // R12 independent writes
        {1'b1,1'b0,1'b0,8'd30,1'b0,1'b0,8'd30,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 5'd7 }, // R7 both new
        {1'b1,1'b0,1'b0,8'd30,1'b0,1'b0,8'd30,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 5'd9 }, // R9 hold
        {1'b1,1'b0,1'b0,8'd30,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 5'd3 }, // R3 mismatch
        {1'b1,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 5'd6 }, // R6 right first
        {1'b1,1'b1,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b1, 5'd4 }, // R4 left ce off
        {1'b1,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 5'd5 }, // R5 right earlier
        {1'b1,1'b0,1'b0,8'd31,1'b1,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0, 5'd4 }, // R4 right ce off
        {1'b1,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 5'd5 }, // R5 left earlier
        {1'b1,1'b0,1'b1,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 5'd11}, // R11 read
        {1'b0,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1, 5'd10}, // R10 slave
        {1'b0,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0, 5'd10}, // R10 slave
        {1'b1,1'b0,1'b0,8'd31,1'b0,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 5'd7 }, // R7 no newer
        {1'b1,1'b1,1'b0,8'd31,1'b1,1'b0,8'd31,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 5'd4 }  // R4 both off
    };

    task automatic check(input int req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d: {lbusy,rbusy,lwr,rwr} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(1, {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}, 4'b1100);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ms_master   = VEC[i][31];
            l_ce_n      = VEC[i][30];
            l_rw_n      = VEC[i][29];
            l_addr      = {{(AW-8){1'b0}}, VEC[i][28:21]};
            r_ce_n      = VEC[i][20];
            r_rw_n      = VEC[i][19];
            r_addr      = {{(AW-8){1'b0}}, VEC[i][18:11]};
            l_busy_in_n = VEC[i][10];
            r_busy_in_n = VEC[i][9];
            @(negedge clk);
            check(int'(VEC[i][4:0]), {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}, VEC[i][8:5]);
            // R8: never both busy
            check(8, {1'b0, (!l_busy_n && !r_busy_n), 2'b00}, 4'b0000);
        end

        // R2: busy appears only after the clock edge that sees the match
        l_ce_n = 1'b0; r_ce_n = 1'b0; l_rw_n = 1'b0; r_rw_n = 1'b0;
        l_addr = 5; r_addr = 5;
        #1;
        check(2, {l_busy_n, r_busy_n, 2'b00}, 4'b1100);
        @(negedge clk);
        check(2, {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}, 4'b1010);

        // R1: reset in the middle of a contention clears the grant
        rst_n = 1'b0;
        @(negedge clk);
        check(1, {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}, 4'b1111);
        rst_n = 1'b1;
        l_ce_n = 1'b1; r_ce_n = 1'b1;
        @(negedge clk);
        check(1, {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}, 4'b1100);

        finish_run();
    end
endmodule